// File: doc/BRIEF.md
# 64-bit Bitfield Extract Unit

This execute-stage unit pulls a contiguous bit field out of a 64-bit source operand and returns it right-aligned, with every bit above the field cleared. An instruction supplies only two 5-bit immediates, an msb field and an lsb field. A 2-bit variant code therefore says how to read them. Each variant adds a bias of 32 to a different field, so that between them the variants reach every field position and width inside the 64-bit word.

The variant code and the two immediates are decoded into a true bit position and field width. A single shift-and-mask datapath then produces the field. Encodings whose field would run past bit 63, and the reserved variant code, raise an illegal flag and give a zero result. One register stage holds the result. A valid bit travels alongside it, which gives the unit one cycle of latency.

Top module: `bfx_unit`

## Requirements
- R1: While rst_ni is low, valid_o, illegal_o and data_o are all zero.
- R2: valid_o equals the value valid_i had at the previous rising clock edge.
- R3: Variant code 0 (base) uses position = lsb_i and width = msb_i + 1.
- R4: Variant code 1 (wide) uses position = lsb_i and width = msb_i + 33, which covers widths 33 to 64.
- R5: Variant code 2 (high) uses position = lsb_i + 32 and width = msb_i + 1, which covers positions 32 to 63.
- R6: data_o holds bits [position+width-1 : position] of src_i in its low bits and zero in every bit at or above width. The base and high variants therefore never set data_o[63:32].
- R7: A width of 64 (variant 1, msb_i = 31, lsb_i = 0) returns src_i unchanged.
- R8: When position + width > 64, illegal_o is 1 and data_o is zero.
- R9: Variant code 3 is reserved. It sets illegal_o to 1 and data_o to zero.
- R10: A cycle in which valid_i is low leaves data_o and illegal_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| op_i | input | 2 | Variant: 0 base, 1 wide, 2 high, 3 reserved |
| src_i | input | 64 | Source operand |
| msb_i | input | 5 | msb immediate field |
| lsb_i | input | 5 | lsb immediate field |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| data_o | output | 64 | Extracted field, zero-filled |
| illegal_o | output | 1 | Field out of range or reserved variant |

## Verification
The properties assume that op_i, msb_i, lsb_i and src_i are known and stable across each rising edge. They also assume that valid_i is held low while reset is active, because the latency property only starts comparing after the first clock edge out of reset. The bench meets these assumptions by driving every input on the falling edge and releasing reset on a falling edge with valid_i low. It then sweeps all 1024 msb/lsb pairs for each variant, so legal and out-of-range encodings both reach the checker. The source data in the sweep is random, all-ones or single-bit.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_WIDE = 2'd1,
    OP_HIGH = 2'd2,
    OP_RSVD = 2'd3
  } bfx_op_e;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int FIELD_W = 5,
  localparam int POS_W  = $clog2(DATA_W),
  localparam int LEN_W  = POS_W + 1
) (
  input  logic [1:0]         op_i,
  input  logic [FIELD_W-1:0] msb_i,
  input  logic [FIELD_W-1:0] lsb_i,
  output logic [POS_W-1:0]   pos_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               bad_o
);
  localparam int BIAS  = DATA_W / 2;
  localparam int SUM_W = LEN_W + 1;

  logic rsvd;

  always_comb begin
    pos_o = POS_W'(lsb_i);
    len_o = LEN_W'(msb_i) + LEN_W'(1);
    rsvd  = 1'b0;
    unique case (bfx_op_e'(op_i))
      OP_WIDE: len_o = LEN_W'(msb_i) + LEN_W'(BIAS + 1);
      OP_HIGH: pos_o = POS_W'(lsb_i) + POS_W'(BIAS);
      OP_RSVD: rsvd  = 1'b1;
      default: ;
    endcase
    bad_o = rsvd || ((SUM_W'(pos_o) + SUM_W'(len_o)) > SUM_W'(DATA_W));
  end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DATA_W = 64,
  localparam int POS_W = $clog2(DATA_W),
  localparam int LEN_W = POS_W + 1
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              bad_i,
  output logic [DATA_W-1:0] field_o
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] mask;

  assign shifted = src_i >> pos_i;

  // per-bit compare: full width needs no out-of-range shift
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign mask[b] = LEN_W'(b) < len_i;
  end

  assign field_o = bad_i ? '0 : (shifted & mask);
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
  parameter int DATA_W  = 64,
  parameter int FIELD_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         op_i,
  input  logic [DATA_W-1:0]  src_i,
  input  logic [FIELD_W-1:0] msb_i,
  input  logic [FIELD_W-1:0] lsb_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               illegal_o
);
  localparam int POS_W = $clog2(DATA_W);
  localparam int LEN_W = POS_W + 1;

  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  len;
  logic              bad;
  logic [DATA_W-1:0] field;

  bfx_decode #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) i_decode (
    .op_i (op_i),
    .msb_i(msb_i),
    .lsb_i(lsb_i),
    .pos_o(pos),
    .len_o(len),
    .bad_o(bad)
  );

  bfx_extract #(.DATA_W(DATA_W)) i_extract (
    .src_i  (src_i),
    .pos_i  (pos),
    .len_i  (len),
    .bad_i  (bad),
    .field_o(field)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o    <= field;
        illegal_o <= bad;
      end
    end
  end
endmodule

// File: rtl/bfx_chk.sv
module bfx_chk #(
  parameter int DATA_W  = 64,
  parameter int FIELD_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [1:0]         op_i,
  input logic [DATA_W-1:0]  src_i,
  input logic [FIELD_W-1:0] msb_i,
  input logic [FIELD_W-1:0] lsb_i,
  input logic               valid_o,
  input logic [DATA_W-1:0]  data_o,
  input logic               illegal_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (valid_o == $past(valid_i)));

  // R8
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (data_o == '0));

  // R9
  reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(valid_i && op_i == 2'd3)) |-> illegal_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(valid_i)) |-> ($stable(data_o) && $stable(illegal_o)));

  // R6
  zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(valid_i && (op_i == 2'd0 || op_i == 2'd2)))
      |-> (data_o[DATA_W-1:DATA_W/2] == '0));

  // R7
  full_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(valid_i && op_i == 2'd1 && msb_i == '1 && lsb_i == '0))
      |-> (data_o == $past(src_i)));
endmodule

bind bfx_unit bfx_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) i_bfx_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .src_i    (src_i),
  .msb_i    (msb_i),
  .lsb_i    (lsb_i),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .illegal_o(illegal_o)
);

// File: tb/test_bfx_unit.sv
module test_bfx_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [1:0]  op_i;
  logic [63:0] src_i;
  logic [4:0]  msb_i;
  logic [4:0]  lsb_i;
  logic        valid_o;
  logic [63:0] data_o;
  logic        illegal_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bfx_unit i_bfx_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_i(src_i), .msb_i(msb_i), .lsb_i(lsb_i),
    .valid_o(valid_o), .data_o(data_o), .illegal_o(illegal_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // independent model on 128-bit intermediates
  task automatic model(input logic [1:0] op, input logic [63:0] src,
                       input logic [4:0] msb, input logic [4:0] lsb,
                       output logic [63:0] res, output logic ill);
    int p, w;
    logic [127:0] m, s;
    p = int'(lsb) + ((op == 2'd2) ? 32 : 0);
    w = int'(msb) + ((op == 2'd1) ? 33 : 1);
    ill = (op == 2'd3) || (p + w > 64);
    m = (128'd1 << w) - 128'd1;
    s = ({64'd0, src} & (m << p)) >> p;
    res = ill ? 64'd0 : s[63:0];
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input logic [63:0] src,
                        input logic [4:0] msb, input logic [4:0] lsb);
    logic [63:0] er;
    logic        ei;
    model(op, src, msb, lsb, er, ei);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; src_i = src; msb_i = msb; lsb_i = lsb;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " data"}, data_o, er);
    check({req, " illegal"}, {63'd0, illegal_o}, {63'd0, ei});
    check({req, " valid"}, {63'd0, valid_o}, 64'd1);
  endtask

  task automatic t_reset();
    // R1
    check("R1 valid", {63'd0, valid_o}, 64'd0);
    check("R1 illegal", {63'd0, illegal_o}, 64'd0);
    check("R1 data", data_o, 64'd0);
  endtask

  task automatic t_sweep(input logic [1:0] op, input string req);
    for (int m = 0; m < 32; m++)
      for (int l = 0; l < 32; l++) begin
        logic [63:0] s;
        case ((m + l) % 3)
          0:       s = {$urandom, $urandom};
          1:       s = 64'hFFFF_FFFF_FFFF_FFFF;
          default: s = 64'd1 << ((m * 7 + l) % 64);
        endcase
        run_op(req, op, s, 5'(m), 5'(l));
      end
  endtask

  task automatic t_directed();
    // R3: base pos 4 width 8 of 0x...A5F0 -> 0x5F
    run_op("R3 base", 2'd0, 64'h0000_0000_0000_A5F0, 5'd7, 5'd4);
    check("R3 base value", data_o, 64'h5F);
    // R4: wide width 40 at pos 8
    run_op("R4 wide", 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd7, 5'd8);
    check("R4 wide value", data_o, 64'h0000_00FF_FFFF_FFFF);
    // R5: high pos 60 width 4
    run_op("R5 high", 2'd2, 64'hC000_0000_0000_0000, 5'd3, 5'd28);
    check("R5 high value", data_o, 64'hC);
    // R6: zero fill above a 1-bit field
    run_op("R6 fill", 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 5'd31);
    check("R6 fill value", data_o, 64'h1);
    // R7: width 64
    run_op("R7 full", 2'd1, 64'h0123_4567_89AB_CDEF, 5'd31, 5'd0);
    check("R7 full value", data_o, 64'h0123_4567_89AB_CDEF);
    // R8: high pos 63 width 2 overflows
    run_op("R8 ovf", 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 5'd1, 5'd31);
    check("R8 ovf flag", {63'd0, illegal_o}, 64'd1);
    check("R8 ovf data", data_o, 64'd0);
    // R9: reserved variant
    run_op("R9 rsvd", 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 5'd0);
    check("R9 rsvd flag", {63'd0, illegal_o}, 64'd1);
  endtask

  task automatic t_hold();
    // R10 / R2
    run_op("R10 setup", 2'd0, 64'h0000_0000_0000_00AB, 5'd7, 5'd0);
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 2'd3; src_i = '1; msb_i = 5'd31; lsb_i = 5'd31;
    @(negedge clk_i);
    check("R10 hold data", data_o, 64'hAB);
    check("R10 hold illegal", {63'd0, illegal_o}, 64'd0);
    check("R2 valid low", {63'd0, valid_o}, 64'd0);
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; src_i = '0; msb_i = '0; lsb_i = '0;
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_directed();
    t_hold();
    t_sweep(2'd0, "R3 sweep");
    t_sweep(2'd1, "R4 sweep");
    t_sweep(2'd2, "R5 sweep");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule